// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block sits between a DMA master and system memory and converts 32-bit device virtual addresses into physical addresses. The virtual address is split into a first-level index, a second-level index and a page offset. On a miss in its small translation cache, the block reads one entry from the first-level table and then one entry from the second-level table that entry names. It returns the translated address and caches the result.

Table entries hold only a page frame number and have no valid bit. Every walk therefore produces a frame, and unmapped space is expected to resolve to a placeholder page set up by software. A register bus lets software set the frame of the first-level table and flush the translation cache. Software can also open or close a gate that stops all traffic to memory. A status bit tells software when the gate is closed and no table read is still in flight.

Top module: `iommu_xlate`

## Requirements
- R1: After reset the gate is closed: the halt control (offset 0x5DC, bit 0) and the halted status (offset 0x5E0, bit 0) both read 1, the root-frame register (offset 0x304) reads 0, `req_ready` is low and the translation cache holds no entries.
- R2: On a miss the unit issues exactly two memory reads, in this order. The first is at address {root frame bits [19:0], vaddr[31:22], 2'b00}. The second is at address {first entry bits [19:0], vaddr[21:12], 2'b00}.
- R3: The translated address is {second entry bits [19:0], vaddr[11:0]}. Entry bits [31:20] are ignored, and an entry value of zero is used as frame 0 rather than treated as invalid.
- R4: A request whose page (vaddr[31:12]) is cached is answered with `rsp_valid` in the cycle after acceptance, and it makes no memory read.
- R5: On a miss, `rsp_valid` rises in the cycle after the cycle in which `mem_rsp_valid` returns the second entry.
- R6: The cache holds 8 pages and replaces them in round-robin order. After 8 distinct fills, a ninth distinct page evicts the page filled earliest, and the pages filled later remain cached.
- R7: A register write to offset 0x300 with bit 0 set empties the cache. The same write with bit 0 clear has no effect.
- R8: A flush that arrives while a walk is in progress, up to and including the cycle in which the second entry returns, does not stop the walk. The walk still returns its correct address, but that translation is not cached.
- R9: While the gate is closed, `req_ready` stays low and `mem_req_valid` stays low. A walk that is in progress pauses before its next read and resumes once the gate reopens.
- R10: The halted status reads 1 only when the gate is closed and no issued table read is still awaiting data. It reads 0 from the cycle after the gate is reopened by a write of 0 to offset 0x5DC.
- R11: The root-frame register keeps 27 bits. A write of all ones reads back as 0x07FF_FFFF.
- R12: Only one walk runs at a time: `req_ready` is low from the cycle after a miss is accepted until that walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: translated address valid |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry (frame number in bits [19:0]) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, zero when not reading) |

## Verification
A cache flush and the fill that ends a walk can fall in the same clock cycle. The bench provokes this by timing a flush write so that it lands on the very edge that captures the returning second-level entry. It then confirms that the response still carries the right address and that the next request to that page walks again, with two more memory reads. The same check is repeated with the flush placed earlier in the walk. In a second timing case, the gate is closed on the same edge that a first-level read is accepted. The bench then confirms that the halted bit stays low until that read's data is back and that no second-level read leaves while the gate is shut.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int OFS_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PFN_W  = PA_W - OFS_W;
    localparam int ROOT_W = 27;
    localparam int RA_W   = 12;
    localparam int RD_W   = 32;

    localparam logic [RA_W-1:0] RG_FLUSH   = 12'h300;
    localparam logic [RA_W-1:0] RG_ROOT    = 12'h304;
    localparam logic [RA_W-1:0] RG_STOP    = 12'h5DC;
    localparam logic [RA_W-1:0] RG_STOPPED = 12'h5E0;

    typedef enum logic [2:0] {
        W_IDLE,
        W_L1_REQ,
        W_L1_WAIT,
        W_L2_REQ,
        W_L2_WAIT
    } walk_st_e;
endpackage

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
    parameter int N     = 8,
    parameter int TAG_W = 20,
    parameter int DAT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [DAT_W-1:0] lk_data,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DAT_W-1:0] fill_data,
    input  logic             flush
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][DAT_W-1:0] dat;
        logic [PTR_W-1:0]        ptr;
    } tlb_t;

    tlb_t s_q, s_d;
    logic [N-1:0] match;

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            assign match[i] = s_q.vld[i] && (s_q.tag[i] == lk_tag);
        end
    endgenerate

    assign lk_hit = |match;

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_data = lk_data | s_q.dat[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.vld = '0;
        end else if (fill_en) begin
            s_d.vld[s_q.ptr] = 1'b1;
            s_d.tag[s_q.ptr] = fill_tag;
            s_d.dat[s_q.ptr] = fill_data;
            s_d.ptr          = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
    import xlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [PFN_W-1:0] root_pfn,
    input  logic             gate_closed,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             busy,
    output logic             outstanding,
    output logic             done,
    output logic [PFN_W-1:0] done_pfn,
    output logic [VPN_W-1:0] cur_vpn
);
    typedef struct packed {
        walk_st_e         st;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] tbl;
    } wstate_t;

    wstate_t s_q, s_d;
    logic    issue_l1;
    logic    unused_hi;

    assign unused_hi     = ^mem_rsp_data[ENT_W-1:PFN_W];
    assign issue_l1      = (s_q.st == W_L1_REQ);
    assign mem_req_valid = (issue_l1 || s_q.st == W_L2_REQ) && !gate_closed;
    assign mem_req_addr  = issue_l1
        ? {root_pfn, s_q.vpn[VPN_W-1 -: IDX_W], 2'b00}
        : {s_q.tbl,  s_q.vpn[IDX_W-1:0],        2'b00};
    assign busy          = (s_q.st != W_IDLE);
    assign outstanding   = (s_q.st == W_L1_WAIT) || (s_q.st == W_L2_WAIT);
    assign done          = (s_q.st == W_L2_WAIT) && mem_rsp_valid;
    assign done_pfn      = mem_rsp_data[PFN_W-1:0];
    assign cur_vpn       = s_q.vpn;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            W_IDLE: begin
                if (start) begin
                    s_d.st  = W_L1_REQ;
                    s_d.vpn = start_vpn;
                end
            end
            W_L1_REQ: begin
                if (mem_req_valid && mem_req_ready) s_d.st = W_L1_WAIT;
            end
            W_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.tbl = mem_rsp_data[PFN_W-1:0];
                    s_d.st  = W_L2_REQ;
                end
            end
            W_L2_REQ: begin
                if (mem_req_valid && mem_req_ready) s_d.st = W_L2_WAIT;
            end
            W_L2_WAIT: begin
                if (mem_rsp_valid) s_d.st = W_IDLE;
            end
            default: s_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: W_IDLE, vpn: '0, tbl: '0};
        else        s_q <= s_d;
    end

    // R2
    l2_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == W_L1_WAIT && mem_rsp_valid)
        |=> (mem_req_addr[PA_W-1:OFS_W] == $past(mem_rsp_data[PFN_W-1:0])));

    // R12
    walk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/iommu_xlate.sv
module iommu_xlate
    import xlt_pkg::*;
#(
    parameter int TLB_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [RD_W-1:0]  reg_wdata,
    output logic [RD_W-1:0]  reg_rdata
);
    typedef struct packed {
        logic              halt;
        logic              halted;
        logic [ROOT_W-1:0] root;
        logic              inval_seen;
        logic              rsp_v;
        logic [PA_W-1:0]   rsp_pa;
        logic [OFS_W-1:0]  off;
    } top_t;

    top_t s_q, s_d;

    logic             accept, start_walk, flush_now;
    logic             tlb_hit, fill_en;
    logic [PFN_W-1:0] tlb_pfn, done_pfn;
    logic [VPN_W-1:0] cur_vpn;
    logic             walk_busy, walk_out, walk_done;
    logic             unused_wd;

    assign unused_wd  = ^reg_wdata[RD_W-1:ROOT_W];
    assign req_ready  = !s_q.halt && !walk_busy;
    assign accept     = req_valid && req_ready;
    assign start_walk = accept && !tlb_hit;
    assign flush_now  = reg_wr && (reg_addr == RG_FLUSH) && reg_wdata[0];
    assign fill_en    = walk_done && !s_q.inval_seen && !flush_now;
    assign rsp_valid  = s_q.rsp_v;
    assign rsp_paddr  = s_q.rsp_pa;

    xlt_tlb #(
        .N     (TLB_N),
        .TAG_W (VPN_W),
        .DAT_W (PFN_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (req_vaddr[VA_W-1:OFS_W]),
        .lk_hit    (tlb_hit),
        .lk_data   (tlb_pfn),
        .fill_en   (fill_en),
        .fill_tag  (cur_vpn),
        .fill_data (done_pfn),
        .flush     (flush_now)
    );

    xlt_walker u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_walk),
        .start_vpn     (req_vaddr[VA_W-1:OFS_W]),
        .root_pfn      (s_q.root[PFN_W-1:0]),
        .gate_closed   (s_q.halt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (walk_busy),
        .outstanding   (walk_out),
        .done          (walk_done),
        .done_pfn      (done_pfn),
        .cur_vpn       (cur_vpn)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        if (reg_wr && reg_addr == RG_STOP) s_d.halt = reg_wdata[0];
        if (reg_wr && reg_addr == RG_ROOT) s_d.root = reg_wdata[ROOT_W-1:0];
        s_d.halted = s_d.halt && s_q.halt && !walk_out;
        if (start_walk) s_d.inval_seen = flush_now;
        else            s_d.inval_seen = s_q.inval_seen || flush_now;
        if (accept) s_d.off = req_vaddr[OFS_W-1:0];
        if (accept && tlb_hit) begin
            s_d.rsp_v  = 1'b1;
            s_d.rsp_pa = {tlb_pfn, req_vaddr[OFS_W-1:0]};
        end else if (walk_done) begin
            s_d.rsp_v  = 1'b1;
            s_d.rsp_pa = {done_pfn, s_q.off};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.halt <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                RG_ROOT:    reg_rdata = RD_W'(s_q.root);
                RG_STOP:    reg_rdata = RD_W'(s_q.halt);
                RG_STOPPED: reg_rdata = RD_W'(s_q.halted);
                default:    reg_rdata = '0;
            endcase
        end
    end

    // R4
    hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tlb_hit) |=> rsp_valid);

    // R9
    gate_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halted |-> (!mem_req_valid && !req_ready));

    // R10
    halted_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halted |-> !walk_out);
endmodule

// File: tb/tb_iommu_xlate.sv
module tb_iommu_xlate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    always #2 clk = ~clk;

    iommu_xlate dut (.*);

    typedef struct { logic [31:0] pa; bit miss; } exp_t;
    exp_t        expq[$];
    logic [31:0] mem_log[$];
    int total = 0, bad = 0, cyc = 0, lat = 1, rsp_drive_cyc = 0;
    logic [26:0] base_model = '0;
    bit done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] memval(input logic [31:0] a);
        logic [19:0] t;
        if (a[31:12] == 20'h00010) return 32'hF0000100 + {22'h0, a[11:2]};
        t = {a[19:12], 12'h000} ^ {10'h000, a[11:2]};
        if (a[11:2] == 10'h3FF) t = 20'h0;
        return {12'hA5C, t};
    endfunction

    function automatic logic [31:0] l1_addr(input logic [31:0] v);
        return {base_model[19:0], v[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] v);
        logic [31:0] e;
        e = memval(l1_addr(v));
        return {e[19:0], v[21:12], 2'b00};
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] v);
        logic [31:0] e;
        e = memval(l2_addr(v));
        return {e[19:0], v[11:0]};
    endfunction

    // memory model: accepts reads, answers after lat cycles
    initial begin
        int cd;
        logic [31:0] pend;
        cd = 0;
        pend = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend;
                    rsp_drive_cyc = cyc;
                end
            end
            if (rst_n && mem_req_valid && mem_req_ready) begin
                mem_log.push_back(mem_req_addr);
                pend = memval(mem_req_addr);
                cd   = lat;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4/R5 unexpected response", rsp_paddr, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(rsp_paddr == e.pa, "R3 translated address", rsp_paddr, e.pa);
                    if (e.miss)
                        chk(cyc == rsp_drive_cyc + 1, "R5 miss response timing", cyc, rsp_drive_cyc + 1);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input bit miss);
        exp_t e;
        e.pa = exp_pa(v);
        e.miss = miss;
        expq.push_back(e);
        req_valid = 1'b1;
        req_vaddr = v;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!miss) chk(rsp_valid == 1'b1, "R4 hit answered next cycle", rsp_valid, 1);
    endtask

    task automatic wait_done(input string tag);
        for (int g = 0; g < 300 && expq.size() != 0; g++) @(negedge clk);
        chk(expq.size() == 0, tag, expq.size(), 0);
    endtask

    task automatic xlate(input logic [31:0] v, input bit miss, input string tag);
        int n0;
        n0 = mem_log.size();
        send(v, miss);
        wait_done(tag);
        if (miss) begin
            chk(mem_log.size() == n0 + 2, {tag, " R2 two reads on miss"}, mem_log.size() - n0, 2);
            if (mem_log.size() == n0 + 2) begin
                chk(mem_log[n0] == l1_addr(v), "R2 first-level read address", mem_log[n0], l1_addr(v));
                chk(mem_log[n0+1] == l2_addr(v), "R2 second-level read address", mem_log[n0+1], l2_addr(v));
            end
        end else begin
            chk(mem_log.size() == n0, {tag, " R4 no read on hit"}, mem_log.size() - n0, 0);
        end
    endtask

    task automatic poll_stopped(input bit want, input string tag);
        logic [31:0] d;
        d = '0;
        for (int g = 0; g < 50; g++) begin
            reg_read(12'h5E0, d);
            if (d[0] == want) break;
            @(negedge clk);
        end
        chk(d[0] == want, tag, d, want);
    endtask

    initial begin
        logic [31:0] d;
        int n0, wc;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; mem_req_ready = 1'b1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(12'h5E0, d); chk(d == 32'h1, "R1 halted status after reset", d, 1);
        reg_read(12'h5DC, d); chk(d == 32'h1, "R1 halt control after reset", d, 1);
        reg_read(12'h304, d); chk(d == 32'h0, "R1 root frame after reset", d, 0);
        chk(req_ready == 1'b0, "R1 req_ready low after reset", req_ready, 0);

        // R9 closed gate: request held, nothing leaves
        req_valid = 1'b1; req_vaddr = 32'h12345678;
        repeat (6) @(negedge clk);
        chk(mem_log.size() == 0, "R9 no read while gate closed", mem_log.size(), 0);
        chk(req_ready == 1'b0, "R9 req_ready low while closed", req_ready, 0);
        req_valid = 1'b0;

        // R11 root register width
        reg_write(12'h304, 32'hFFFFFFFF);
        reg_read(12'h304, d); chk(d == 32'h07FFFFFF, "R11 root keeps 27 bits", d, 32'h07FFFFFF);
        reg_write(12'h304, 32'h00000010);
        base_model = 27'h10;

        reg_write(12'h5DC, 32'h0);
        poll_stopped(1'b0, "R10 halted clears after reopen");

        // R1 cache empty, R2 R3 R5 walks, R4 hit
        xlate(32'h12345678, 1, "R1 first request walks");
        xlate(32'h12345ABC, 0, "R4 same page hit");
        xlate(32'hFFFFF123, 1, "R3 zero entry used as frame");
        xlate(32'h00000000, 1, "R5 miss at address zero");

        // R12 single walk
        lat = 5;
        n0 = mem_log.size();
        send(32'h40000444, 1);
        chk(req_ready == 1'b0, "R12 req_ready low during walk", req_ready, 0);
        wait_done("R12 walk completes");
        chk(mem_log.size() == n0 + 2, "R12 reads of slow walk", mem_log.size() - n0, 2);
        lat = 1;

        // R7 flush with bit0 clear then set
        reg_write(12'h300, 32'h0000_0002);
        xlate(32'h12345000, 0, "R7 flush with bit0 clear ignored");
        reg_write(12'h300, 32'h1);
        xlate(32'h12345000, 1, "R7 flush empties cache");

        // R6 round robin
        reg_write(12'h300, 32'h1);
        for (int i = 0; i < 9; i++) xlate(32'h20000000 + i * 4096, 1, "R6 fill distinct pages");
        xlate(32'h20000010, 1, "R6 earliest page evicted");
        xlate(32'h20002010, 0, "R6 later page still cached");
        xlate(32'h20001010, 1, "R6 next oldest evicted by refill");

        // R8 flush mid-walk
        lat = 6;
        send(32'h30000abc, 1);
        @(negedge clk);
        reg_write(12'h300, 32'h1);
        wait_done("R8 walk returns despite flush");
        lat = 1;
        xlate(32'h30000abc, 1, "R8 result not cached");

        // R8 flush on the same edge as the final entry
        lat = 3;
        send(32'h3040_0100, 1);
        repeat (7) @(negedge clk);
        wc = cyc;
        reg_write(12'h300, 32'h1);
        wait_done("R8 coincident flush walk returns");
        chk(rsp_drive_cyc == wc, "R8 flush coincided with second entry", rsp_drive_cyc, wc);
        lat = 1;
        xlate(32'h3040_0100, 1, "R8 coincident fill suppressed");

        // R9 R10 close gate mid-walk
        lat = 4;
        n0 = mem_log.size();
        send(32'h5000_0def, 1);
        reg_write(12'h5DC, 32'h1);
        @(negedge clk);
        reg_read(12'h5E0, d); chk(d == 32'h0, "R10 halted low while read outstanding", d, 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mem_req_valid) chk(1'b0, "R9 request while gate closed", 1, 0);
        end
        reg_read(12'h5E0, d); chk(d == 32'h1, "R10 halted after drain", d, 1);
        chk(mem_log.size() == n0 + 1, "R9 second read held back", mem_log.size() - n0, 1);
        chk(expq.size() == 1, "R9 walk paused", expq.size(), 1);
        reg_write(12'h5DC, 32'h0);
        reg_read(12'h5E0, d); chk(d == 32'h0, "R10 halted clears on reopen", d, 0);
        wait_done("R9 walk resumes after reopen");
        chk(mem_log.size() == n0 + 2, "R9 walk finished both reads", mem_log.size() - n0, 2);
        lat = 1;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule